// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is a single bank of sixteen general-purpose pins controlled through a small 16-bit register interface. Each pin can act as an input or an output, with an output value and an alternate-function select bit that go straight to the pad logic. Every pad input passes through a two-flop synchroniser. The synchronised level can be read back as the pin-status register. Software can use that level to pick the next edge polarity when it wants to catch both edges.

Each pin can also raise an interrupt. Three per-pin registers choose the trigger:

- trigger type: edge or level;
- edge polarity: rising or falling;
- level polarity: active-high or active-low.

A fired trigger sets a sticky bit in the interrupt-status register. The bit is set whatever the interrupt mask holds, and a write to the status register clears it. The bank drives one summary interrupt line to an upstream aggregator. That line is the OR of the status bits whose mask bit is 0. A separate sleep-mask register works the same way to drive a wake request.

The register interface is plain control: writes are accepted in the cycle `bus_wr_en` is high, with no back-pressure. Read data follows `bus_addr` combinationally. Neither path carries a valid/ready stream.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset:
  - direction, output, alternate-function, level-polarity and interrupt-status all read 0;
  - interrupt-mask, trigger-type, edge-polarity and sleep-mask all read 0xFFFF;
  - `irq_out` and `wake_out` are 0.
- R2: Register addresses are 0 direction, 1 output, 2 alternate-function, 4 interrupt-mask, 5 trigger-type, 6 edge-polarity, 7 level-polarity, 8 interrupt-status and 9 sleep-mask.
  - Writes take effect at the clock edge and read back the written value.
  - Direction bit n = 1 drives `pad_oe[n]`; output bit n drives `pad_out[n]`; alternate-function bit n drives `alt_sel[n]`.
  - Unmapped addresses read 0.
- R3: Address 3 returns the synchronised pad level. A pad change becomes visible after the second rising clock edge. Writes to address 3 have no effect.
- R4: A pin with trigger-type bit = 1 and edge-polarity bit = 1 sets its status bit on a rising pad edge, at the third clock edge after the pad changes. A falling edge does not set it.
- R5: A pin with trigger-type bit = 1 and edge-polarity bit = 0 sets its status bit on a falling pad edge only.
- R6: A pin with trigger-type bit = 0 sets its status bit in every cycle its synchronised level equals its level-polarity bit (1 = active-high, 0 = active-low).
- R7: Status bits stay set until a write to address 8, which clears every bit whatever the write data; the write data can never set a bit.
- R8: A trigger that fires in the same cycle as a status write leaves its status bit set.
- R9: `irq_out` is 1 exactly when some status bit is set with its interrupt-mask bit = 0; a mask bit of 1 blocks that pin.
- R10: `wake_out` is 1 exactly when some status bit is set with its sleep-mask bit = 0.
- R11: Status bits record triggers on masked pins as well as on unmasked ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address for read and write |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational from `bus_addr`) |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables (1 = drive) |
| alt_sel | output | 16 | Alternate-function selects |
| irq_out | output | 1 | Summary interrupt to the aggregator |
| wake_out | output | 1 | Wake request |

## Verification
The bound assertions check, on every cycle:
- the direction write reaching `pad_oe` one cycle later;
- the sticky behaviour of the status bits between clears;
- the rule that a clear keeps exactly the triggers firing in that same cycle;
- the blocking effect of a fully set interrupt mask or sleep mask;
- the summary line rising whenever an unmasked bit is set.

Only the directed scenarios can show the properties that depend on pad timing:
- the two-cycle synchroniser latency and the third-edge status timing;
- which edge or level each polarity setting responds to;
- that writes to the pin-status address are ignored;
- that triggers on masked pins are still recorded.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    A_DIR   = 4'd0,
    A_DOUT  = 4'd1,
    A_ALT   = 4'd2,
    A_PIN   = 4'd3,
    A_IMASK = 4'd4,
    A_TTYPE = 4'd5,
    A_EPOL  = 4'd6,
    A_LPOL  = 4'd7,
    A_STAT  = 4'd8,
    A_WAKEM = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] ttype,
  input  logic [W-1:0] epol,
  input  logic [W-1:0] lpol,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, edge_hit, level_hit;
    always_comb begin
      rise      = lvl[i] & ~prev[i];
      fall      = ~lvl[i] & prev[i];
      edge_hit  = epol[i] ? rise : fall;
      level_hit = ~(lvl[i] ^ lpol[i]);
      hit[i]    = ttype[i] ? edge_hit : level_hit;
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pin_lvl,
  input  logic [W-1:0]      hit,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      alt,
  output logic [W-1:0]      imask,
  output logic [W-1:0]      ttype,
  output logic [W-1:0]      epol,
  output logic [W-1:0]      lpol,
  output logic [W-1:0]      stat,
  output logic [W-1:0]      wakem,
  output logic [W-1:0]      rdata
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic stat_clr;
  assign stat_clr = wr_en && (reg_addr_e'(addr) == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir   <= '0;
      dout  <= '0;
      alt   <= '0;
      imask <= ALL_ONES;
      ttype <= ALL_ONES;
      epol  <= ALL_ONES;
      lpol  <= '0;
      wakem <= ALL_ONES;
    end else if (wr_en) begin
      case (reg_addr_e'(addr))
        A_DIR:   dir   <= wdata;
        A_DOUT:  dout  <= wdata;
        A_ALT:   alt   <= wdata;
        A_IMASK: imask <= wdata;
        A_TTYPE: ttype <= wdata;
        A_EPOL:  epol  <= wdata;
        A_LPOL:  lpol  <= wdata;
        A_WAKEM: wakem <= wdata;
        default: ;
      endcase
    end
  end

  // Sticky status: a clear only drops bits with no trigger in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat_clr ? '0 : stat) | hit;
  end

  always_comb begin
    case (reg_addr_e'(addr))
      A_DIR:   rdata = dir;
      A_DOUT:  rdata = dout;
      A_ALT:   rdata = alt;
      A_PIN:   rdata = pin_lvl;
      A_IMASK: rdata = imask;
      A_TTYPE: rdata = ttype;
      A_EPOL:  rdata = epol;
      A_LPOL:  rdata = lpol;
      A_STAT:  rdata = stat;
      A_WAKEM: rdata = wakem;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   alt_sel,
  output logic              irq_out,
  output logic              wake_out
);
  logic [PINS-1:0] pin_lvl, hit;
  logic [PINS-1:0] dir, dout, alt, imask, ttype, epol, lpol, stat, wakem;

  gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_lvl)
  );

  gpio_trigger #(.W(PINS)) u_trig (
    .clk(clk), .rst_n(rst_n), .lvl(pin_lvl),
    .ttype(ttype), .epol(epol), .lpol(lpol), .hit(hit)
  );

  gpio_regfile #(.W(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .pin_lvl(pin_lvl), .hit(hit),
    .dir(dir), .dout(dout), .alt(alt), .imask(imask), .ttype(ttype),
    .epol(epol), .lpol(lpol), .stat(stat), .wakem(wakem), .rdata(bus_rdata)
  );

  assign pad_oe   = dir;
  assign pad_out  = dout;
  assign alt_sel  = alt;
  assign irq_out  = |(stat & ~imask);
  assign wake_out = |(stat & ~wakem);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr_en,
  input logic [3:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] pad_oe,
  input logic         irq_out,
  input logic         wake_out,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] stat_q,
  input logic [W-1:0] hit_q,
  input logic [W-1:0] wakem_q
);
  logic clr_wr;
  assign clr_wr = bus_wr_en && (bus_addr == 4'd8);

  assert_dir_drives_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 4'd0) |=> (pad_oe == $past(bus_wdata)));

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_clear_keeps_events_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (stat_q == $past(hit_q)));

  assert_mask_blocks_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq_out);

  assert_unmasked_raises_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~mask_q) != '0) |-> irq_out);

  assert_sleep_blocks_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wakem_q == '1) |-> !wake_out);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_oe(pad_oe), .irq_out(irq_out),
  .wake_out(wake_out), .mask_q(imask), .stat_q(stat), .hit_q(hit),
  .wakem_q(wakem)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [15:0] pad_in = 16'd0;
  logic [15:0] pad_out, pad_oe, alt_sel;
  logic        irq_out, wake_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_sel(alt_sel),
    .irq_out(irq_out), .wake_out(wake_out)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_pad(input logic [15:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(4'd0, v); check("R1", "dir", v, 16'h0000);
    rd(4'd1, v); check("R1", "dout", v, 16'h0000);
    rd(4'd2, v); check("R1", "alt", v, 16'h0000);
    rd(4'd4, v); check("R1", "imask", v, 16'hFFFF);
    rd(4'd5, v); check("R1", "ttype", v, 16'hFFFF);
    rd(4'd6, v); check("R1", "epol", v, 16'hFFFF);
    rd(4'd7, v); check("R1", "lpol", v, 16'h0000);
    rd(4'd8, v); check("R1", "stat", v, 16'h0000);
    rd(4'd9, v); check("R1", "sleep", v, 16'hFFFF);
    check("R1", "irq_out", {15'd0, irq_out}, 16'd0);
    check("R1", "wake_out", {15'd0, wake_out}, 16'd0);
  endtask

  task automatic t_pad_ctrl;
    logic [15:0] v;
    wr(4'd0, 16'hA5A5);
    wr(4'd1, 16'h0F0F);
    wr(4'd2, 16'h3C3C);
    check("R2", "pad_oe", pad_oe, 16'hA5A5);
    check("R2", "pad_out", pad_out, 16'h0F0F);
    check("R2", "alt_sel", alt_sel, 16'h3C3C);
    rd(4'd1, v); check("R2", "dout readback", v, 16'h0F0F);
    rd(4'd15, v); check("R2", "unmapped read", v, 16'h0000);
    wr(4'd0, 16'h0000); wr(4'd1, 16'h0000); wr(4'd2, 16'h0000);
    check("R2", "pad_oe restored", pad_oe, 16'h0000);
  endtask

  task automatic t_pin_status;
    logic [15:0] v;
    @(negedge clk);
    pad_in = 16'h8001;
    @(negedge clk);
    rd(4'd3, v); check("R3", "pin after one edge", v, 16'h0000);
    @(negedge clk);
    rd(4'd3, v); check("R3", "pin after two edges", v, 16'h8001);
    wr(4'd3, 16'hFFFF);
    rd(4'd3, v); check("R3", "pin write ignored", v, 16'h8001);
    set_pad(16'h0000);
    wr(4'd8, 16'h0000);
  endtask

  task automatic t_rise;
    logic [15:0] v;
    @(negedge clk);
    pad_in = 16'h0004;
    repeat (2) @(negedge clk);
    rd(4'd8, v); check("R4", "stat before third edge", v, 16'h0000);
    @(negedge clk);
    rd(4'd8, v); check("R4", "rising edge stat", v, 16'h0004);
    check("R11", "masked pin recorded, irq low", {15'd0, irq_out}, 16'd0);
    wr(4'd4, 16'hFFFB);
    check("R9", "unmasked irq high", {15'd0, irq_out}, 16'd1);
    wr(4'd8, 16'h0000);
    set_pad(16'h0000);
    rd(4'd8, v); check("R4", "falling edge ignored", v, 16'h0000);
    check("R9", "irq low after clear", {15'd0, irq_out}, 16'd0);
    wr(4'd4, 16'hFFFF);
  endtask

  task automatic t_fall;
    logic [15:0] v;
    wr(4'd6, 16'hFFDF);
    set_pad(16'h0020);
    rd(4'd8, v); check("R5", "rising ignored", v, 16'h0000);
    set_pad(16'h0000);
    rd(4'd8, v); check("R5", "falling edge stat", v, 16'h0020);
    wr(4'd8, 16'h0000);
    wr(4'd6, 16'hFFFF);
  endtask

  task automatic t_level;
    logic [15:0] v;
    wr(4'd7, 16'h0080);
    wr(4'd5, 16'hFF7F);
    rd(4'd8, v); check("R6", "level-high idle", v, 16'h0000);
    set_pad(16'h0080);
    rd(4'd8, v); check("R6", "level-high stat", v, 16'h0080);
    wr(4'd8, 16'h0000);
    rd(4'd8, v); check("R8", "clear with active level", v, 16'h0080);
    set_pad(16'h0000);
    wr(4'd8, 16'h0000);
    rd(4'd8, v); check("R7", "clear after level drops", v, 16'h0000);
    wr(4'd7, 16'h0000);
    repeat (2) @(negedge clk);
    rd(4'd8, v); check("R6", "level-low stat", v, 16'h0080);
    wr(4'd5, 16'hFFFF);
    wr(4'd8, 16'h0000);
    rd(4'd8, v); check("R7", "cleared", v, 16'h0000);
  endtask

  task automatic t_sticky;
    logic [15:0] v;
    wr(4'd8, 16'hFFFF);
    rd(4'd8, v); check("R7", "write data cannot set", v, 16'h0000);
    set_pad(16'h0100);
    set_pad(16'h0000);
    repeat (5) @(negedge clk);
    rd(4'd8, v); check("R7", "bit stays set", v, 16'h0100);
    wr(4'd8, 16'h0100);
    rd(4'd8, v); check("R7", "any write clears", v, 16'h0000);
  endtask

  task automatic t_wake;
    set_pad(16'h0008);
    check("R10", "sleep masked", {15'd0, wake_out}, 16'd0);
    wr(4'd9, 16'hFFF7);
    check("R10", "wake high", {15'd0, wake_out}, 16'd1);
    check("R9", "irq still masked", {15'd0, irq_out}, 16'd0);
    wr(4'd8, 16'h0000);
    check("R10", "wake low after clear", {15'd0, wake_out}, 16'd0);
    set_pad(16'h0000);
    wr(4'd9, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pad_ctrl();
    t_pin_status();
    t_rise();
    t_fall();
    t_level();
    t_sticky();
    t_wake();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule